// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Data Cache Lookup

This block is the lookup and refill engine of an 8-way, 32 KiB first-level data cache with 64-byte lines. A load or store address arrives on a valid/ready request channel. The low 12 address bits are identical before and after translation, so they choose the set and the word directly. In the same cycle that the eight candidate lines of that set are read, the upper 20 bits go to an external translation port. That port answers with a hit flag and a 24-bit physical page number. The page number serves as the physical tag and picks among the eight candidates.

Each access gets exactly one response: a hit with its word, a translation-miss retry, or a miss. A miss is answered once the line has been fetched from the next memory level over a request channel that carries a 36-bit line address. Only one access is in flight at a time. The request channel stays not-ready from acceptance until the response, which stalls the requester. The memory request channel obeys back-pressure: a raised request holds its address, direction and data until `mem_req_ready` is seen. The response channels (`rsp_*` and `mem_rsp_*`) carry no back-pressure, and their consumers take every pulse.

Top module: `vipt_l1_cache`

## Requirements
- R1: After reset every line is invalid: `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and the first access to any address reports a miss.
- R2: Address bits [11:6] select one of 64 sets and bits [5:2] select one of 16 32-bit words in the line. While an access is looked up, `tlb_lookup` is 1 and `tlb_vpn` carries address bits [31:12].
- R3: With a translation hit and a valid way whose tag equals `tlb_ppn`, the response has `rsp_hit`=1, `rsp_retry`=0 and the addressed word. It arrives one cycle after the lookup cycle, and at most one way matches.
- R4: With a translation miss, the response has `rsp_retry`=1 and `rsp_hit`=0 even if a stored tag would match. No memory request is made and no line changes.
- R5: On a translation hit with no matching way, a read request for `{tlb_ppn, addr[11:6], 6'b0}` is issued. When the line returns it is installed, and the response carries `rsp_hit`=0 with the addressed word. Later accesses to that line hit.
- R6: Two virtual pages that translate to the same physical page share cached lines, so an access through either page hits a line fetched through the other.
- R7: The fill victim is the lowest-numbered invalid way. If no way is invalid, the victim comes from a 7-bit tree pseudo-LRU per set. The tree is updated on every hit and every fill so that each node points away from the most recently used way.
- R8: A store that hits, or a store miss once filled, marks the line dirty. A dirty victim is written back (`mem_req_write`=1, address `{stored tag, set, 6'b0}`, the old line as data) before the read for the new line. A clean victim causes no write.
- R9: From acceptance until its response, `req_ready` is 0. A memory request held while `mem_req_ready` is 0 keeps its address and direction stable.
- R10: Every memory request address has bits [5:0] equal to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can accept an access (idle) |
| req_vaddr | input | 32 | Virtual byte address of the access |
| req_store | input | 1 | Access is a store (marks line dirty) |
| tlb_lookup | output | 1 | Translation lookup in progress |
| tlb_vpn | output | 20 | Virtual page number to translate |
| tlb_hit | input | 1 | Translation found, same cycle |
| tlb_ppn | input | 24 | Physical page number, used as tag |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Access hit in the cache |
| rsp_retry | output | 1 | Translation missed; retry later |
| rsp_data | output | 32 | Addressed word |
| mem_req_valid | output | 1 | Next-level request valid |
| mem_req_ready | input | 1 | Next level accepts the request |
| mem_req_write | output | 1 | Request is a line write-back |
| mem_req_addr | output | 36 | Line-aligned physical address |
| mem_req_wdata | output | 512 | Line data for a write-back |
| mem_rsp_valid | input | 1 | Fill line returned |
| mem_rsp_data | input | 512 | Fill line data |

## Verification
Every set is first touched once to prove the cold-miss path and the fill address, and then all 16 word offsets of the filled line are read to separate set selection from word selection. A translation miss aimed at a resident line shows that a tag match is discarded. An access through a second virtual page with the same translation shows that lines are shared by physical address. One set is filled past capacity with a fixed touch order, and the later hit/miss pattern reveals which way the pseudo-LRU tree picked each time. This distinguishes invalid-first choice, tree update on hits and tree update on fills. A dirty eviction checks write-back order, address and data against a clean one, and a stalled memory channel shows that the request holds steady and the requester stays blocked.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOK,
    S_EVICT,
    S_FETCH,
    S_WAIT
  } cstate_e;
endpackage

// File: rtl/vipt_way_cmp.sv
module vipt_way_cmp #(
  parameter int WAYS  = 8,
  parameter int TAG_W = 24,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            vld,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           ptag,
  output logic [WAYS-1:0]            match,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  // one comparator per way, all in parallel
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = vld[w] && (tags[w] == ptag);
  end

  always_comb begin
    hit     = |match;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/vipt_plru.sv
module vipt_plru #(
  parameter int WAYS = 8,
  parameter int SETS = 64,
  localparam int WAY_W = $clog2(WAYS),
  localparam int IDX_W = $clog2(SETS),
  localparam int NODES = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [WAYS-1:0]  inv_vec,
  input  logic             touch,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim
);
  logic [NODES-1:0] tree_q [SETS];
  logic [NODES-1:0] cur, upd;
  logic [WAY_W-1:0] walk_way, free_way;

  assign cur = tree_q[set_idx];

  // node bit 0 = victim on the left child, 1 = right child
  always_comb begin
    int n;
    upd = cur;
    n   = 0;
    for (int l = 0; l < WAY_W; l++) begin
      upd[n] = ~touch_way[WAY_W-1-l];
      n      = 2 * n + 1 + int'(touch_way[WAY_W-1-l]);
    end
  end

  always_comb begin
    int n;
    walk_way = '0;
    n        = 0;
    for (int l = 0; l < WAY_W; l++) begin
      walk_way[WAY_W-1-l] = cur[n];
      n                   = 2 * n + 1 + int'(cur[n]);
    end
  end

  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (inv_vec[w]) free_way = WAY_W'(w);
    end
  end

  assign victim = (|inv_vec) ? free_way : walk_way;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (touch) begin
      tree_q[set_idx] <= upd;
    end
  end
endmodule

// File: rtl/vipt_l1_cache.sv
module vipt_l1_cache
  import vipt_pkg::*;
#(
  parameter int WAYS       = 8,
  parameter int SETS       = 64,
  parameter int LINE_BYTES = 64,
  parameter int WORD_W     = 32,
  parameter int VA_W       = 32,
  parameter int PA_W       = 36,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int BOFF_W = $clog2(WORD_W / 8),
  localparam int WPL    = LINE_BYTES * 8 / WORD_W,
  localparam int WSEL_W = $clog2(WPL),
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int TAG_W  = PA_W - OFF_W - IDX_W,
  localparam int VPN_W  = VA_W - OFF_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_store,
  output logic              tlb_lookup,
  output logic [VPN_W-1:0]  tlb_vpn,
  input  logic              tlb_hit,
  input  logic [TAG_W-1:0]  tlb_ppn,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_retry,
  output logic [WORD_W-1:0] rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [PA_W-1:0]   mem_req_addr,
  output logic [LINE_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_data
);
  cstate_e st_q;
  logic [VA_W-1:BOFF_W] va_q;
  logic                 store_q;
  logic [TAG_W-1:0]     ptag_q;
  logic [WAY_W-1:0]     vic_q;
  logic                 rsp_valid_q, rsp_hit_q, rsp_retry_q;
  logic [WORD_W-1:0]    rsp_data_q;

  // tag, state and data arrays
  logic [TAG_W-1:0]  tag_q [WAYS][SETS];
  logic [SETS-1:0]   vld_q [WAYS];
  logic [SETS-1:0]   dty_q [WAYS];
  logic [LINE_W-1:0] dat_q [WAYS*SETS];

  logic unused_lsb;
  assign unused_lsb = ^req_vaddr[BOFF_W-1:0];

  logic [IDX_W-1:0]  idx;
  logic [WSEL_W-1:0] wsel;
  assign idx  = va_q[OFF_W +: IDX_W];
  assign wsel = va_q[BOFF_W +: WSEL_W];

  // parallel read of every way of the indexed set
  logic [WAYS-1:0]            cand_vld, cand_dty;
  logic [WAYS-1:0][TAG_W-1:0] cand_tag;
  logic [LINE_W-1:0]          cand_line [WAYS];
  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    localparam logic [WAY_W-1:0] WI = WAY_W'(w);
    assign cand_vld[w]  = vld_q[w][idx];
    assign cand_dty[w]  = dty_q[w][idx];
    assign cand_tag[w]  = tag_q[w][idx];
    assign cand_line[w] = dat_q[{WI, idx}];
  end

  logic [WAYS-1:0]  way_match;
  logic             tag_hit;
  logic [WAY_W-1:0] hit_way, victim;

  vipt_way_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) i_cmp (
    .vld(cand_vld), .tags(cand_tag), .ptag(tlb_ppn),
    .match(way_match), .hit(tag_hit), .hit_way(hit_way)
  );

  logic             lru_touch;
  logic [WAY_W-1:0] lru_way;
  assign lru_touch = (st_q == S_LOOK && tlb_hit && tag_hit) ||
                     (st_q == S_WAIT && mem_rsp_valid);
  assign lru_way   = (st_q == S_LOOK) ? hit_way : vic_q;

  vipt_plru #(.WAYS(WAYS), .SETS(SETS)) i_lru (
    .clk(clk), .rst(rst), .set_idx(idx), .inv_vec(~cand_vld),
    .touch(lru_touch), .touch_way(lru_way), .victim(victim)
  );

  logic [LINE_W-1:0] hit_line;
  logic [WORD_W-1:0] hit_word, fill_word;
  assign hit_line  = cand_line[hit_way];
  assign hit_word  = hit_line[int'(wsel) * WORD_W +: WORD_W];
  assign fill_word = mem_rsp_data[int'(wsel) * WORD_W +: WORD_W];

  assign req_ready     = (st_q == S_IDLE);
  assign tlb_lookup    = (st_q == S_LOOK);
  assign tlb_vpn       = va_q[VA_W-1 -: VPN_W];
  assign mem_req_valid = (st_q == S_EVICT) || (st_q == S_FETCH);
  assign mem_req_write = (st_q == S_EVICT);
  assign mem_req_addr  = (st_q == S_EVICT) ? {tag_q[vic_q][idx], idx, {OFF_W{1'b0}}}
                                           : {ptag_q, idx, {OFF_W{1'b0}}};
  assign mem_req_wdata = dat_q[{vic_q, idx}];

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_retry = rsp_retry_q;
  assign rsp_data  = rsp_data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= S_IDLE;
      va_q        <= '0;
      store_q     <= 1'b0;
      ptag_q      <= '0;
      vic_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_retry_q <= 1'b0;
      rsp_data_q  <= '0;
      for (int w = 0; w < WAYS; w++) begin
        vld_q[w] <= '0;
        dty_q[w] <= '0;
      end
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (req_valid) begin
          va_q    <= req_vaddr[VA_W-1:BOFF_W];
          store_q <= req_store;
          st_q    <= S_LOOK;
        end
        S_LOOK: begin
          if (!tlb_hit) begin
            rsp_valid_q <= 1'b1;
            rsp_retry_q <= 1'b1;
            rsp_hit_q   <= 1'b0;
            rsp_data_q  <= '0;
            st_q        <= S_IDLE;
          end else if (tag_hit) begin
            rsp_valid_q <= 1'b1;
            rsp_retry_q <= 1'b0;
            rsp_hit_q   <= 1'b1;
            rsp_data_q  <= hit_word;
            if (store_q) dty_q[hit_way][idx] <= 1'b1;
            st_q        <= S_IDLE;
          end else begin
            ptag_q <= tlb_ppn;
            vic_q  <= victim;
            st_q   <= (cand_vld[victim] && cand_dty[victim]) ? S_EVICT : S_FETCH;
          end
        end
        S_EVICT: if (mem_req_ready) st_q <= S_FETCH;
        S_FETCH: if (mem_req_ready) st_q <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          vld_q[vic_q][idx] <= 1'b1;
          dty_q[vic_q][idx] <= store_q;
          rsp_valid_q       <= 1'b1;
          rsp_retry_q       <= 1'b0;
          rsp_hit_q         <= 1'b0;
          rsp_data_q        <= fill_word;
          st_q              <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // line payload and tag storage, written only by a fill
  always_ff @(posedge clk) begin
    if (st_q == S_WAIT && mem_rsp_valid) begin
      tag_q[vic_q][idx]   <= ptag_q;
      dat_q[{vic_q, idx}] <= mem_rsp_data;
    end
  end
endmodule

// File: rtl/vipt_l1_cache_chk.sv
module vipt_l1_cache_chk #(
  parameter int WAYS  = 8,
  parameter int OFF_W = 6,
  parameter int PA_W  = 36
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_retry,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic            mem_req_write,
  input logic [PA_W-1:0] mem_req_addr,
  input logic [WAYS-1:0] way_match
);
  p_flags_excl_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !(rsp_hit && rsp_retry));

  p_one_way_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(way_match));

  p_single_rsp_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_ready_only_with_rsp_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(req_ready) |-> rsp_valid);

  p_mem_blocks_req_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  p_mem_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  p_line_align_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0));
endmodule

bind vipt_l1_cache vipt_l1_cache_chk #(
  .WAYS(WAYS), .OFF_W(OFF_W), .PA_W(PA_W)
) i_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_retry(rsp_retry),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .way_match(way_match)
);

// File: tb/test_vipt_l1_cache.sv
module test_vipt_l1_cache;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0, req_store = 1'b0;
  logic [31:0]  req_vaddr = '0;
  logic         req_ready;
  logic         tlb_lookup, tlb_hit;
  logic [19:0]  tlb_vpn;
  logic [23:0]  tlb_ppn;
  logic         rsp_valid, rsp_hit, rsp_retry;
  logic [31:0]  rsp_data;
  logic         mem_req_valid, mem_req_write;
  logic         mrdy = 1'b1;
  logic [35:0]  mem_req_addr;
  logic [511:0] mem_req_wdata;
  logic         mem_rsp_valid = 1'b0;
  logic [511:0] mem_rsp_data = '0;

  int errs = 0, checks = 0;
  int rd_cnt = 0, wr_cnt = 0, evt = 0, rd_evt = 0, wr_evt = 0;
  logic [35:0] last_rd_addr = '0, last_wr_addr = '0;
  logic [31:0] last_wr_w0 = '0;
  logic        a_hit, a_retry;
  logic [31:0] a_data;
  logic [19:0] a_vpn;
  int          a_lat;

  always #2 clk = ~clk;

  // translation model: top nibble F misses; top nibble is dropped otherwise
  assign tlb_hit = (tlb_vpn[19:16] != 4'hF);
  assign tlb_ppn = {8'h3C, tlb_vpn[15:0]};

  vipt_l1_cache i_vipt_l1_cache (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_store(req_store), .tlb_lookup(tlb_lookup),
    .tlb_vpn(tlb_vpn), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_retry(rsp_retry),
    .rsp_data(rsp_data), .mem_req_valid(mem_req_valid), .mem_req_ready(mrdy),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [31:0] mword(input logic [35:0] pa);
    return pa[33:2] ^ 32'h9E3779B9;
  endfunction

  function automatic logic [35:0] pa_of(input logic [31:0] va);
    return {8'h3C, va[27:12], va[11:0]};
  endfunction

  function automatic logic [35:0] line_of(input logic [31:0] va);
    logic [35:0] p;
    p = pa_of(va);
    return {p[35:6], 6'b0};
  endfunction

  function automatic logic [511:0] line_data(input logic [35:0] la);
    logic [511:0] d;
    for (int w = 0; w < 16; w++) d[w*32 +: 32] = mword({la[35:6], w[3:0], 2'b00});
    return d;
  endfunction

  function automatic logic [31:0] mkva(input logic [3:0] hi, input logic [15:0] pg,
                                       input logic [5:0] set, input logic [3:0] w);
    return {hi, pg, set, w, 2'b00};
  endfunction

  task automatic chk(input string req, input bit ok, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // next-level memory: fixed latency, data computed from the address
  initial begin
    int dly;
    bit pend;
    logic [35:0] pa;
    pend = 1'b0;
    dly  = 0;
    pa   = '0;
    forever begin
      @(negedge clk);
      if (mem_rsp_valid) mem_rsp_valid = 1'b0;
      if (!rst && mem_req_valid && mrdy) begin
        evt++;
        if (mem_req_write) begin
          wr_cnt++; wr_evt = evt;
          last_wr_addr = mem_req_addr;
          last_wr_w0   = mem_req_wdata[31:0];
        end else begin
          rd_cnt++; rd_evt = evt;
          last_rd_addr = mem_req_addr;
          pa = mem_req_addr; pend = 1'b1; dly = 3;
        end
      end else if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = line_data(pa);
          pend = 1'b0;
        end else dly--;
      end
    end
  end

  task automatic access(input logic [31:0] va, input bit st);
    @(negedge clk);
    req_vaddr = va; req_store = st; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    a_vpn = tlb_vpn;
    a_lat = 0;
    while (!rsp_valid) begin
      @(negedge clk);
      a_lat++;
    end
    a_hit = rsp_hit; a_retry = rsp_retry; a_data = rsp_data;
  endtask

  task automatic acc_chk(input logic [31:0] va, input bit st, input bit exp_hit,
                         input string req);
    int rd0;
    rd0 = rd_cnt;
    access(va, st);
    chk({req, " retry"}, a_retry == 1'b0, 64'(a_retry), 64'd0);
    chk({req, " hit"}, a_hit == exp_hit, 64'(a_hit), 64'(exp_hit));
    chk({req, " data"}, a_data == mword(pa_of(va)), 64'(a_data), 64'(mword(pa_of(va))));
    if (!exp_hit) begin
      chk("R5 one read", rd_cnt == rd0 + 1, 64'(rd_cnt), 64'(rd0 + 1));
      chk("R5 read addr", last_rd_addr == line_of(va), 64'(last_rd_addr), 64'(line_of(va)));
    end else begin
      chk("R3 latency", a_lat == 1, 64'(a_lat), 64'd1);
    end
  endtask

  initial begin
    int wr0, rd0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ready", req_ready == 1'b1, 64'(req_ready), 64'd1);
    chk("R1 rsp idle", rsp_valid == 1'b0, 64'(rsp_valid), 64'd0);
    chk("R1 mem idle", mem_req_valid == 1'b0, 64'(mem_req_valid), 64'd0);
    @(posedge clk); #1 rst = 1'b0;

    // R1, R2, R3, R5: every set cold, then every word of the line
    for (int s = 0; s < 64; s++) begin
      acc_chk(mkva(4'h0, 16'h0010, 6'(s), 4'(s)), 1'b0, 1'b0, "R1 cold miss");
      chk("R2 vpn", a_vpn == 20'h00010, 64'(a_vpn), 64'h10);
      for (int w = 0; w < 16; w++)
        acc_chk(mkva(4'h0, 16'h0010, 6'(s), 4'(w)), 1'b0, 1'b1, "R2 word select");
    end

    // R4: translation miss on a resident line is discarded
    rd0 = rd_cnt;
    access(mkva(4'hF, 16'h0010, 6'd5, 4'd3), 1'b0);
    chk("R4 retry", a_retry == 1'b1, 64'(a_retry), 64'd1);
    chk("R4 no hit", a_hit == 1'b0, 64'(a_hit), 64'd0);
    chk("R4 no mem", rd_cnt == rd0, 64'(rd_cnt), 64'(rd0));
    acc_chk(mkva(4'h0, 16'h0010, 6'd5, 4'd3), 1'b0, 1'b1, "R4 line kept");

    // R6: alias page shares the physical line
    acc_chk(mkva(4'h1, 16'h0010, 6'd5, 4'd7), 1'b0, 1'b1, "R6 alias hit");
    acc_chk(mkva(4'h7, 16'h0010, 6'd40, 4'd0), 1'b0, 1'b1, "R6 alias hit");

    // R7: replacement order in set 9 (way0 already holds page 0x0010)
    wr0 = wr_cnt;
    for (int k = 1; k < 8; k++)
      acc_chk(mkva(4'h0, 16'h0100 + 16'(k), 6'd9, 4'd1), 1'b0, 1'b0, "R7 fill invalid");
    acc_chk(mkva(4'h0, 16'h0010, 6'd9, 4'd2), 1'b0, 1'b1, "R7 first tag kept");
    for (int k = 1; k < 8; k++)
      acc_chk(mkva(4'h0, 16'h0100 + 16'(k), 6'd9, 4'd2), 1'b0, 1'b1, "R7 all hit");
    acc_chk(mkva(4'h0, 16'h0200, 6'd9, 4'd0), 1'b0, 1'b0, "R7 new tag");
    acc_chk(mkva(4'h0, 16'h0010, 6'd9, 4'd0), 1'b0, 1'b0, "R7 way0 evicted");
    acc_chk(mkva(4'h0, 16'h0105, 6'd9, 4'd0), 1'b0, 1'b1, "R7 way5 kept");
    acc_chk(mkva(4'h0, 16'h0104, 6'd9, 4'd0), 1'b0, 1'b0, "R7 way4 evicted");
    acc_chk(mkva(4'h0, 16'h0102, 6'd9, 4'd0), 1'b0, 1'b0, "R7 way2 evicted");
    acc_chk(mkva(4'h0, 16'h0101, 6'd9, 4'd0), 1'b0, 1'b1, "R7 way1 kept");
    acc_chk(mkva(4'h0, 16'h0103, 6'd9, 4'd0), 1'b0, 1'b1, "R7 way3 kept");
    acc_chk(mkva(4'h0, 16'h0106, 6'd9, 4'd0), 1'b0, 1'b0, "R7 way6 evicted");
    chk("R8 clean evict no write", wr_cnt == wr0, 64'(wr_cnt), 64'(wr0));

    // R8: dirty line in set 20 written back before refill
    acc_chk(mkva(4'h0, 16'h0010, 6'd20, 4'd0), 1'b1, 1'b1, "R8 store hit");
    for (int k = 1; k < 8; k++)
      acc_chk(mkva(4'h0, 16'h0300 + 16'(k), 6'd20, 4'd4), 1'b0, 1'b0, "R8 fill");
    acc_chk(mkva(4'h0, 16'h0010, 6'd20, 4'd4), 1'b0, 1'b1, "R8 touch");
    for (int k = 1; k < 8; k++)
      acc_chk(mkva(4'h0, 16'h0300 + 16'(k), 6'd20, 4'd5), 1'b0, 1'b1, "R8 touch");
    wr0 = wr_cnt;
    acc_chk(mkva(4'h0, 16'h0380, 6'd20, 4'd9), 1'b0, 1'b0, "R8 dirty victim");
    chk("R8 one write", wr_cnt == wr0 + 1, 64'(wr_cnt), 64'(wr0 + 1));
    chk("R8 write addr", last_wr_addr == line_of(mkva(4'h0, 16'h0010, 6'd20, 4'd0)),
        64'(last_wr_addr), 64'(line_of(mkva(4'h0, 16'h0010, 6'd20, 4'd0))));
    chk("R8 write data", last_wr_w0 == mword(line_of(mkva(4'h0, 16'h0010, 6'd20, 4'd0))),
        64'(last_wr_w0), 64'(mword(line_of(mkva(4'h0, 16'h0010, 6'd20, 4'd0)))));
    chk("R8 write before read", wr_evt < rd_evt, 64'(wr_evt), 64'(rd_evt));

    // R9: stalled memory channel keeps the request and blocks the requester
    @(posedge clk); #1 mrdy = 1'b0;
    fork
      acc_chk(mkva(4'h0, 16'h0400, 6'd30, 4'd6), 1'b0, 1'b0, "R9 stalled miss");
      begin
        repeat (6) @(negedge clk);
        chk("R9 req held", mem_req_valid == 1'b1, 64'(mem_req_valid), 64'd1);
        chk("R9 read dir", mem_req_write == 1'b0, 64'(mem_req_write), 64'd0);
        chk("R10 held addr", mem_req_addr == line_of(mkva(4'h0, 16'h0400, 6'd30, 4'd0)),
            64'(mem_req_addr), 64'(line_of(mkva(4'h0, 16'h0400, 6'd30, 4'd0))));
        chk("R9 not ready", req_ready == 1'b0, 64'(req_ready), 64'd0);
        @(posedge clk); #1 mrdy = 1'b1;
      end
    join
    acc_chk(mkva(4'h0, 16'h0400, 6'd30, 4'd6), 1'b0, 1'b1, "R9 line filled");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule